// File: doc/BRIEF.md
# Programmable I2C Clock Phase Generator

This block drives the SCL line of an I2C bus master from the system clock. Four 16-bit count registers set the two phase lengths. One pair holds the standard-speed values and the other pair the fast-speed values. A speed input picks the pair, and the block samples it when it accepts a command. The protocol engine asks for one of two things: a full bit slot, which is a low phase followed by a high phase, or a held high phase. The held high phase gives the setup and hold times around start and stop conditions. The block answers each finished phase with a one-cycle pulse, so the engine can move SDA at the right moment.

The low phase is timed from the cycle in which the block pulls SCL low. The high phase is not timed from the release of SCL. It is timed from the point where the synchronized line is seen high. A target that holds SCL low therefore stretches the clock, and a brief low sample restarts the high count. Counts may be written only while the enable input is low. Clearing enable stops the generator at once and releases SCL.

Top module: `scl_gen`

## Requirements
- R1: After reset, and whenever no phase is running, `scl_out` is 1 and neither `low_done` nor `high_done` is asserted. While `enable` is 0, `ready` is 0.
- R2: `cfg_addr` selects the count register: 0 is standard high, 1 is standard low, 2 is fast high, 3 is fast low. `fast_mode`=1 selects the fast pair and 0 selects the standard pair. The block samples `fast_mode` only on the edge that accepts a command, so a later change has no effect on that slot.
- R3: When `cmd_bit` is accepted on a clock edge, `scl_out` is 0 from the next cycle for exactly Leff+1 cycles, where Leff is the selected low count. `low_done` is 1 on the last of those cycles only, and `scl_out` returns to 1 in the following cycle.
- R4: Let h0 be the first cycle of a high phase, with `scl_out` 1, and let g be the last cycle at or after h0 whose closing edge sees `scl_in` low (g = h0-1 if there is none). Then `high_done` is 1 in cycle g+1+Heff+7. If the line rises at once, the high phase therefore lasts Heff+8 cycles.
- R5: Holding `scl_in` low during a high phase stretches it, and a single low sample in the middle of the count restarts the count as R4 states.
- R6: A programmed high count below 6 acts as 6, and a programmed low count below 8 acts as 8. Values from the minimum up to the largest register value are used unchanged.
- R7: A write with `cfg_we`=1 while `enable`=1 is ignored, and the old count stays in effect.
- R8: When `enable` is 0 on an edge, the generator goes idle. From the next cycle `scl_out` is 1 and no done pulse occurs, and commands given while `enable` is 0 are ignored.
- R9: `ready` = `enable` and (idle or `high_done`). A command present while `ready` is 1 is accepted, and `cmd_bit` wins over `cmd_hold`. A `cmd_bit` accepted in the `high_done` cycle pulls `scl_out` low in the very next cycle. Commands given while `ready` is 0 are ignored.
- R10: An accepted `cmd_hold` runs a high phase, timed as in R4 with h0 the cycle after acceptance, during which `scl_out` never goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Generator enable; counts writable only while 0 |
| fast_mode | input | 1 | 1 selects the fast count pair |
| cfg_we | input | 1 | Count register write strobe |
| cfg_addr | input | 2 | Count register select |
| cfg_wdata | input | CW | Count value |
| cmd_bit | input | 1 | Request a low phase followed by a high phase |
| cmd_hold | input | 1 | Request a high phase only |
| scl_in | input | 1 | Sensed SCL line level |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| ready | output | 1 | A command is accepted this cycle |
| low_done | output | 1 | Last cycle of a low phase |
| high_done | output | 1 | Last cycle of a high phase |

## Verification
The bench builds the block with CW=6, so each count register has only 64 values. It sweeps every one of them for each of the four registers, and it computes the low and high phase lengths from the clamp and overhead rules. The small width brings every value into reach, from both clamped regions up to the all-ones maximum. It also leaves room for stretch depths, mid-count glitches, the speed-latch case and back-to-back slots.

// File: rtl/scl_gen.sv
module scl_gen #(
  parameter int CW   = 16,
  parameter int HMIN = 6,
  parameter int LMIN = 8,
  parameter int OVH  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fast_mode,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          cmd_bit,
  input  logic          cmd_hold,
  input  logic          scl_in,
  output logic          scl_out,
  output logic          ready,
  output logic          low_done,
  output logic          high_done
);
  localparam int RW = CW + 1;
  localparam logic [RW-1:0] HADD = RW'(OVH - 2);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t           st;
  logic [CW-1:0] std_hi, std_lo, fst_hi, fst_lo;
  logic [RW-1:0] cnt;
  logic          fast_q, first, scl_s;

  function automatic logic [RW-1:0] clamp(input logic [CW-1:0] v, input int lo);
    return (v < CW'(lo)) ? RW'(lo) : {1'b0, v};
  endfunction

  wire [CW-1:0] lo_sel  = fast_mode ? fst_lo : std_lo;
  wire [CW-1:0] hi_sel  = fast_q ? fst_hi : std_hi;
  wire [RW-1:0] hi_load = clamp(hi_sel, HMIN) + HADD;
  wire          at_zero = (cnt == '0);

  assign scl_out   = (st != S_LOW);
  assign low_done  = (st == S_LOW) && at_zero;
  assign high_done = (st == S_HIGH) && !first && scl_s && at_zero;
  assign ready     = enable && ((st == S_IDLE) || high_done);

  wire accept = ready && (cmd_bit || cmd_hold);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      std_hi <= '0;
      std_lo <= '0;
      fst_hi <= '0;
      fst_lo <= '0;
    end else if (cfg_we && !enable) begin
      case (cfg_addr)
        2'd0: std_hi <= cfg_wdata;
        2'd1: std_lo <= cfg_wdata;
        2'd2: fst_hi <= cfg_wdata;
        default: fst_lo <= cfg_wdata;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scl_s <= 1'b1;
    else        scl_s <= scl_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      fast_q <= 1'b0;
      first  <= 1'b0;
    end else if (!enable) begin
      st    <= S_IDLE;
      cnt   <= '0;
      first <= 1'b0;
    end else if (accept) begin
      fast_q <= fast_mode;
      if (cmd_bit) begin
        st  <= S_LOW;
        cnt <= clamp(lo_sel, LMIN);
      end else begin
        st    <= S_HIGH;
        first <= 1'b1;
      end
    end else begin
      case (st)
        S_LOW:
          if (at_zero) begin
            st    <= S_HIGH;
            first <= 1'b1;
          end else cnt <= cnt - 1'b1;
        S_HIGH:
          if (first || !scl_s) begin
            cnt   <= hi_load;
            first <= 1'b0;
          end else if (at_zero) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: ;
      endcase
    end

  // R3
  low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_done |=> scl_out);

  // R8
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_out && !low_done && !high_done));

  // R9
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_out) |-> $past(cmd_bit && ready));

  // R7
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && enable) |=> ($stable(std_hi) && $stable(std_lo) && $stable(fst_hi) && $stable(fst_lo)));

  // R4
  high_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_done |-> $past(scl_in));
endmodule

// File: tb/test_scl_gen.sv
module test_scl_gen;
  localparam int CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, fast_mode = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic cmd_bit = 1'b0, cmd_hold = 1'b0, stretch = 1'b0;
  logic scl_out, ready, low_done, high_done;
  wire  scl_line = scl_out & ~stretch;

  int vectors = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  scl_gen #(.CW(CW)) i_scl_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cmd_bit(cmd_bit), .cmd_hold(cmd_hold), .scl_in(scl_line),
    .scl_out(scl_out), .ready(ready), .low_done(low_done), .high_done(high_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = CW'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int eff(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  task automatic slot(input bit isbit, input int lv, input int hv,
                      input int st, input int gl, input bit flip, input string req);
    int nl, ldi, nh, lastlow, expl, exph, bad;
    bit done;
    expl = eff(lv, 8) + 1;
    lastlow = -1;
    if (st > 0) lastlow = st - 1;
    if (gl > lastlow) lastlow = gl;
    exph = lastlow + 1 + eff(hv, 6) + 8;
    @(negedge clk);
    chk(ready == 1'b1, {req, " ready"}, int'(ready), 1);
    cmd_bit = isbit; cmd_hold = !isbit;
    @(negedge clk);
    cmd_bit = 1'b0; cmd_hold = 1'b0;
    if (flip) fast_mode = ~fast_mode;
    nl = 0; ldi = -1; bad = 0;
    if (isbit)
      while (!scl_out && nl < 300) begin
        if (low_done) ldi = nl;
        nl++;
        @(negedge clk);
      end
    nh = 0; done = 1'b0;
    while (!done && nh < 600) begin
      stretch = (nh < st) || (nh == gl);
      if (!scl_out || low_done) bad++;
      if (high_done) done = 1'b1;
      nh++;
      if (!done) @(negedge clk);
    end
    stretch = 1'b0;
    if (isbit) begin
      chk(nl == expl, {req, " R3 low length"}, nl, expl);
      chk(ldi == expl - 1, {req, " R3 low_done position"}, ldi, expl - 1);
    end
    chk(nh == exph, {req, " R4 high length"}, nh, exph);
    chk(bad == 0, {req, " R10 line held released in high"}, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scl_out == 1'b1, "R1 scl after reset", int'(scl_out), 1);
    chk(ready == 1'b0, "R1 ready while disabled", int'(ready), 0);
    chk(!low_done && !high_done, "R1 no pulses", int'(low_done | high_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_out == 1'b1, "R1 scl idle", int'(scl_out), 1);

    // R3 R6 standard low sweep
    for (int v = 0; v < 64; v++) begin
      enable = 1'b0; wr(1, v); wr(0, 9); wr(2, 40); wr(3, 40);
      enable = 1'b1; fast_mode = 1'b0;
      slot(1'b1, v, 9, 0, -1, 1'b0, "R6 std low sweep");
    end
    // R4 R6 standard high sweep
    for (int v = 0; v < 64; v++) begin
      enable = 1'b0; wr(0, v); wr(1, 10);
      enable = 1'b1;
      slot(1'b1, 10, v, 0, -1, 1'b0, "R6 std high sweep");
    end
    // R2 fast pair sweeps
    enable = 1'b0; wr(0, 50); wr(1, 50);
    for (int v = 0; v < 64; v++) begin
      enable = 1'b0; wr(3, v); wr(2, 7);
      enable = 1'b1; fast_mode = 1'b1;
      slot(1'b1, v, 7, 0, -1, 1'b0, "R2 fast low sweep");
    end
    for (int v = 0; v < 64; v++) begin
      enable = 1'b0; wr(2, v); wr(3, 12);
      enable = 1'b1; fast_mode = 1'b1;
      slot(1'b1, 12, v, 0, -1, 1'b0, "R2 fast high sweep");
    end

    // R2 speed sampled at acceptance
    enable = 1'b0; wr(0, 20); wr(1, 22); wr(2, 6); wr(3, 8);
    enable = 1'b1; fast_mode = 1'b0;
    slot(1'b1, 22, 20, 0, -1, 1'b1, "R2 speed latch std");
    slot(1'b1, 8, 6, 0, -1, 1'b1, "R2 speed latch fast");
    fast_mode = 1'b0;

    // R5 stretching and glitch restart
    for (int s = 0; s < 12; s++) slot(1'b1, 22, 20, s, -1, 1'b0, "R5 stretch");
    for (int g = 0; g < 20; g += 3) slot(1'b1, 22, 20, 0, g, 1'b0, "R5 glitch");

    // R10 hold phase
    for (int s = 0; s < 4; s++) slot(1'b0, 22, 20, s, -1, 1'b0, "R10 hold");

    // R7 write while enabled ignored
    wr(0, 40); wr(1, 3);
    slot(1'b1, 22, 20, 0, -1, 1'b0, "R7 locked write");

    // R9 back-to-back and priority
    @(negedge clk);
    cmd_bit = 1'b1;
    begin
      int n = 0;
      @(negedge clk);
      while (!high_done && n < 200) begin n++; @(negedge clk); end
      @(negedge clk);
      chk(scl_out == 1'b0, "R9 back-to-back low", int'(scl_out), 0);
      cmd_bit = 1'b0;
      n = 0;
      while (!high_done && n < 200) begin n++; @(negedge clk); end
    end
    @(negedge clk);
    cmd_bit = 1'b1; cmd_hold = 1'b1;
    @(negedge clk);
    cmd_bit = 1'b0; cmd_hold = 1'b0;
    chk(scl_out == 1'b0, "R9 bit wins over hold", int'(scl_out), 0);
    // R9 command while busy ignored: pulse hold mid-low, then count remaining low
    begin
      int n = 1;
      cmd_hold = 1'b1;
      @(negedge clk);
      cmd_hold = 1'b0;
      while (!scl_out && n < 200) begin n++; @(negedge clk); end
      chk(n == 23, "R9 busy command ignored", n, 23);
      n = 0;
      while (!high_done && n < 200) begin n++; @(negedge clk); end
    end

    // R8 disable aborts
    @(negedge clk);
    cmd_bit = 1'b1;
    @(negedge clk);
    cmd_bit = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_out == 1'b1, "R8 released after disable", int'(scl_out), 1);
    chk(ready == 1'b0, "R8 not ready", int'(ready), 0);
    cmd_bit = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(scl_out && !low_done && !high_done, "R8 commands ignored", int'(scl_out), 1);
    end
    cmd_bit = 1'b0;
    enable = 1'b1;
    slot(1'b1, 22, 20, 0, -1, 1'b0, "R8 resume");
    @(negedge clk);
    chk(scl_out && !low_done && !high_done, "R1 idle after slot", int'(scl_out), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule